// File: doc/BRIEF.md
# Quarter-Duty Half-Bias LCD Sequencer

This block produces the drive codes for a multiplexed segment LCD with four common lines and twenty segment lines, so up to eighty segments can be shown. Each pin gets a two-bit code for low, mid or high level. An external resistor or level network turns these codes into voltages at half bias. The scan cycles through the four commons at quarter duty. The block flips the drive polarity on alternate frames, so the glass sees no average DC.

Software loads the display one digit at a time over a write port. A digit is the four-bit on/off nibble of one segment pin, with one bit for each common. Writes go into a staging copy. The staging copy is moved to the displayed copy only at a frame boundary, so a half-written picture is never shown. A configuration vector hands any of the last eight segment pins over to general-purpose port use. A backup input blanks the glass and keeps the pattern.

Top module: `lcd_quad_seq`

## Requirements
- R1: While reset is high, and from the first sampled cycle after a reset edge, every common and every unreleased segment code is 2'b00. Reset also clears the whole pattern to all-off.
- R2: The level codes are 2'b00 for low, 2'b01 for mid, 2'b10 for high and 2'b11 for a pin released to port use.
- R3: After reset or backup ends, common 0 is selected for 250 clocks. Then commons 1, 2 and 3 follow, 250 clocks each. One frame is 1000 clocks, which gives 75 Hz from a 75 kHz clock.
- R4: In every active cycle exactly one common is selected. All the other commons are at mid (2'b01).
- R5: Frame polarity alternates. In even frames (the first frame after a restart is even) the selected common is high. In odd frames it is low.
- R6: Bit k of digit j is the state of segment pin j while common k is selected. When that bit is 1 the pin takes the full level opposite to the selected common. When it is 0 the pin takes the same level as the selected common.
- R7: A digit write becomes visible at the first frame boundary after it is captured. A write captured in the last cycle of a frame first shows one frame later. The frame in progress is never changed.
- R8: A write with a digit index of 20 or above changes no segment at any time.
- R9: Release bit i (0..7) controls segment pin 12+i. A 1 makes that pin report 2'b11 at once, whatever the reset, backup or scan state. A 0 keeps the pin as a segment.
- R10: From the cycle after backup is sampled high, all commons and unreleased segments are 2'b00. Writes made during backup are kept. When backup drops, the scan restarts at common 0 in an even frame and shows the latest pattern at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock (75 kHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| backup | input | 1 | Backup request: blanks the glass and restarts the scan |
| wr_en | input | 1 | Digit write strobe |
| wr_digit | input | 5 | Digit (segment pin) index of the write |
| wr_nibble | input | 4 | On/off bits of the digit, bit k for common k |
| pin_release | input | 8 | Per-pin hand-over of segment pins 12..19 to port use |
| com_code | output | 4x2 | Level code of each common line |
| seg_code | output | 20x2 | Level code of each segment line |

## Verification
The bench goes after the frame edge. One write lands in the very last cycle of a frame. It must show only a frame later, and a design that sampled the staging copy after the write would show it a frame early. Another write is made in mid-frame, and the bench checks every cycle up to the edge: a design that drove the glass straight from the staging copy would change the picture part-way through a scan. The bench also crosses the point where polarity flips, where a wrong inversion leaves DC on the glass and turns on segments on unselected commons. It writes to indices just past the last digit, where a truncated index would overwrite a real digit. Finally it checks that backup and reset blank the commons while released pins stay released, and that the scan restarts in phase.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_REL  = 2'b11
    } lvl_e;

    typedef struct packed {
        logic blank;
        logic odd;
    } scan_ctx_t;

    function automatic lvl_e sel_level(input logic odd);
        return odd ? LVL_LOW : LVL_HIGH;
    endfunction

    function automatic lvl_e opposite(input lvl_e l);
        return (l == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
    parameter int NUM_COM    = 4,
    parameter int PHASE_CLKS = 250,
    parameter int CW         = $clog2(NUM_COM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          run,
    output logic [CW-1:0] com_idx,
    output logic          frame_odd,
    output logic          frame_end
);
    localparam int PW = $clog2(PHASE_CLKS);
    localparam logic [PW-1:0] PH_LAST  = PW'(PHASE_CLKS - 1);
    localparam logic [CW-1:0] COM_LAST = CW'(NUM_COM - 1);

    logic [PW-1:0] ph_cnt;
    logic          ph_wrap;

    assign ph_wrap   = run && !hold && (ph_cnt == PH_LAST);
    assign frame_end = ph_wrap && (com_idx == COM_LAST);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ph_cnt    <= '0;
            com_idx   <= '0;
            frame_odd <= 1'b0;
        end else if (run) begin
            if (ph_cnt == PH_LAST) begin
                ph_cnt <= '0;
                if (com_idx == COM_LAST) begin
                    com_idx   <= '0;
                    frame_odd <= ~frame_odd;
                end else begin
                    com_idx <= com_idx + 1'b1;
                end
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ph_wrap && !hold) |=> $stable(com_idx));

    // R5
    parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && !hold) |=> $stable(frame_odd));

    // R5
    parity_flip_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (frame_odd != $past(frame_odd)));

endmodule

// File: rtl/lcd_pattern_bank.sv
module lcd_pattern_bank #(
    parameter int NUM_SEG = 20,
    parameter int NUM_COM = 4,
    parameter int IDX_W   = $clog2(NUM_SEG)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [NUM_COM-1:0]                wr_data,
    input  logic                              load,
    output logic [NUM_SEG-1:0][NUM_COM-1:0]   active
);
    logic [NUM_SEG-1:0][NUM_COM-1:0] staged;

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst) begin
                staged[j] <= '0;
                active[j] <= '0;
            end else begin
                if (wr_en && (wr_idx == IDX_W'(j)))
                    staged[j] <= wr_data;
                if (load)
                    active[j] <= staged[j];
            end
        end
    end

    // R7
    active_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_idx) >= NUM_SEG)) |=> $stable(staged));

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
    import lcd_seq_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int CW      = $clog2(NUM_COM)
) (
    input  logic [CW-1:0]            com_idx,
    input  scan_ctx_t                ctx,
    output logic [NUM_COM-1:0][1:0]  com_code
);
    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        lvl_e lvl;
        always_comb begin
            if (ctx.blank)
                lvl = LVL_LOW;
            else if (com_idx == CW'(k))
                lvl = sel_level(ctx.odd);
            else
                lvl = LVL_MID;
        end
        assign com_code[k] = lvl;
    end

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG    = 20,
    parameter int NUM_COM    = 4,
    parameter int NUM_SHARED = 8,
    parameter int CW         = $clog2(NUM_COM)
) (
    input  logic [NUM_SEG-1:0][NUM_COM-1:0] active,
    input  logic [CW-1:0]                   com_idx,
    input  scan_ctx_t                       ctx,
    input  logic [NUM_SHARED-1:0]           pin_release,
    output logic [NUM_SEG-1:0][1:0]         seg_code
);
    localparam int FIRST_SHARED = NUM_SEG - NUM_SHARED;

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
        logic rel;
        logic on;
        lvl_e lvl;

        if (j >= FIRST_SHARED) begin : g_shared
            assign rel = pin_release[j - FIRST_SHARED];
        end else begin : g_fixed
            assign rel = 1'b0;
        end

        assign on = active[j][com_idx];

        always_comb begin
            if (rel)
                lvl = LVL_REL;
            else if (ctx.blank)
                lvl = LVL_LOW;
            else if (on)
                lvl = opposite(sel_level(ctx.odd));
            else
                lvl = sel_level(ctx.odd);
        end
        assign seg_code[j] = lvl;
    end

endmodule

// File: rtl/lcd_quad_seq.sv
module lcd_quad_seq
    import lcd_seq_pkg::*;
#(
    parameter int NUM_COM    = 4,
    parameter int NUM_SEG    = 20,
    parameter int NUM_SHARED = 8,
    parameter int PHASE_CLKS = 250,
    parameter int DIGIT_W    = $clog2(NUM_SEG)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          backup,
    input  logic                          wr_en,
    input  logic [DIGIT_W-1:0]            wr_digit,
    input  logic [NUM_COM-1:0]            wr_nibble,
    input  logic [NUM_SHARED-1:0]         pin_release,
    output logic [NUM_COM-1:0][1:0]       com_code,
    output logic [NUM_SEG-1:0][1:0]       seg_code
);
    localparam int CW = $clog2(NUM_COM);

    logic                            blank_q;
    logic [CW-1:0]                   com_idx;
    logic                            frame_odd;
    logic                            frame_end;
    logic [NUM_SEG-1:0][NUM_COM-1:0] active;
    scan_ctx_t                       ctx;

    always_ff @(posedge clk) begin
        if (rst || backup)
            blank_q <= 1'b1;
        else
            blank_q <= 1'b0;
    end

    assign ctx.blank = blank_q;
    assign ctx.odd   = frame_odd;

    lcd_scan_timer #(
        .NUM_COM(NUM_COM), .PHASE_CLKS(PHASE_CLKS), .CW(CW)
    ) u_timer (
        .clk(clk), .rst(rst), .hold(backup), .run(!blank_q),
        .com_idx(com_idx), .frame_odd(frame_odd), .frame_end(frame_end)
    );

    lcd_pattern_bank #(
        .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .IDX_W(DIGIT_W)
    ) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_digit),
        .wr_data(wr_nibble), .load(frame_end || backup), .active(active)
    );

    lcd_com_drv #(
        .NUM_COM(NUM_COM), .CW(CW)
    ) u_com (
        .com_idx(com_idx), .ctx(ctx), .com_code(com_code)
    );

    lcd_seg_drv #(
        .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .NUM_SHARED(NUM_SHARED), .CW(CW)
    ) u_seg (
        .active(active), .com_idx(com_idx), .ctx(ctx),
        .pin_release(pin_release), .seg_code(seg_code)
    );

    logic [NUM_COM-1:0] com_driven;
    for (genvar k = 0; k < NUM_COM; k++) begin : g_drv_flag
        assign com_driven[k] = (com_code[k] != LVL_MID);
    end

    // R4
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_q |-> ($countones(com_driven) == 1));

    // R10
    backup_blank_chk: assert property (@(posedge clk) disable iff (rst)
        backup |=> (com_code == '0));

    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_rel_chk
        // R9
        release_code_chk: assert property (@(posedge clk) disable iff (rst)
            pin_release[i] |-> (seg_code[NUM_SEG - NUM_SHARED + i] == LVL_REL));
    end

endmodule

// File: tb/sim_lcd_quad_seq.sv
module sim_lcd_quad_seq;
    localparam int NC  = 4;
    localparam int NS  = 20;
    localparam int NSH = 8;
    localparam int PH  = 250;
    localparam int FR  = PH * NC;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst = 1'b1;
    logic               backup = 1'b0;
    logic               wr_en = 1'b0;
    logic [4:0]         wr_digit = '0;
    logic [3:0]         wr_nibble = '0;
    logic [NSH-1:0]     pin_release = '0;
    logic [NC-1:0][1:0] com_code;
    logic [NS-1:0][1:0] seg_code;

    lcd_quad_seq u0 (
        .clk(clk), .rst(rst), .backup(backup), .wr_en(wr_en),
        .wr_digit(wr_digit), .wr_nibble(wr_nibble), .pin_release(pin_release),
        .com_code(com_code), .seg_code(seg_code)
    );

    int   checks = 0;
    int   errors = 0;
    int   t = 0;
    bit   blank = 1'b1;
    bit   finished = 1'b0;
    logic [3:0] shown [NS];
    logic [3:0] pend  [NS];

    function automatic logic [1:0] exp_com(int k);
        int  c;
        bit  odd;
        if (blank) return 2'b00;
        c   = (t / PH) % NC;
        odd = ((t / FR) % 2) == 1;
        if (k == c) return odd ? 2'b00 : 2'b10;
        return 2'b01;
    endfunction

    function automatic logic [1:0] exp_seg(int j);
        int         c;
        bit         odd;
        logic [1:0] sel;
        if (j >= NS - NSH && pin_release[j - (NS - NSH)]) return 2'b11;
        if (blank) return 2'b00;
        c   = (t / PH) % NC;
        odd = ((t / FR) % 2) == 1;
        sel = odd ? 2'b00 : 2'b10;
        if (shown[j][c]) return odd ? 2'b10 : 2'b00;
        return sel;
    endfunction

    task automatic check_pins(input string req);
        logic [NC-1:0][1:0] ec;
        logic [NS-1:0][1:0] es;
        for (int k = 0; k < NC; k++) ec[k] = exp_com(k);
        for (int j = 0; j < NS; j++) es[j] = exp_seg(j);
        checks++;
        if (com_code !== ec || seg_code !== es) begin
            errors++;
            $display("FAIL %s t=%0d com act=%h exp=%h seg act=%h exp=%h",
                     req, t, com_code, ec, seg_code, es);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            for (int j = 0; j < NS; j++) begin shown[j] = '0; pend[j] = '0; end
            blank = 1'b1;
            t = 0;
        end else begin
            if (backup) begin
                for (int j = 0; j < NS; j++) shown[j] = pend[j];
            end else if (!blank && (t % FR) == FR - 1) begin
                for (int j = 0; j < NS; j++) shown[j] = pend[j];
            end
            if (wr_en && wr_digit < NS) pend[wr_digit] = wr_nibble;
            if (backup) begin blank = 1'b1; t = 0; end
            else if (blank) begin blank = 1'b0; t = 0; end
            else t++;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin step(); check_pins(req); end
    endtask

    task automatic run_to(input int pos, input string req);
        while ((t % FR) != pos) begin step(); check_pins(req); end
    endtask

    task automatic write_digit(input int d, input logic [3:0] v, input string req);
        wr_en = 1'b1; wr_digit = 5'(d); wr_nibble = v;
        step();
        wr_en = 1'b0;
        check_pins(req);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        step(); step(); step();
        check_pins("R1 held in reset");
        checks++;
        if (com_code !== '0) begin
            errors++;
            $display("FAIL R1 commons act=%h exp=0", com_code);
        end
        rst = 1'b0;
        step();
        check_pins("R3 first cycle after reset");
    endtask

    task automatic t_scan();
        run(2 * FR + 5, "R2 R3 R4 R5 scan of empty pattern");
    endtask

    task automatic t_pattern();
        run_to(300, "R3 scan");
        write_digit(0, 4'b0101, "R7 frame in progress");
        write_digit(5, 4'b1010, "R7 frame in progress");
        write_digit(12, 4'b0011, "R7 frame in progress");
        write_digit(19, 4'b1111, "R7 frame in progress");
        run_to(FR - 1, "R7 old picture until boundary");
        run(2 * FR, "R6 R7 new picture both polarities");
    endtask

    task automatic t_edge_write();
        run_to(FR - 1, "R6 scan");
        write_digit(3, 4'b1001, "R7 write in last cycle");
        run(FR + 2, "R7 last-cycle write deferred one frame");
    endtask

    task automatic t_range();
        run_to(10, "R6 scan");
        write_digit(20, 4'b1111, "R8 index 20");
        write_digit(31, 4'b1111, "R8 index 31");
        run(2 * FR, "R8 no segment changed");
    endtask

    task automatic t_release();
        pin_release = 8'b1000_0001;
        step();
        check_pins("R9 pins 12 and 19 released");
        run(300, "R9 partial release");
        pin_release = 8'hFF;
        run(20, "R9 all shared pins released");
        pin_release = 8'h00;
        run(20, "R9 pins returned to segments");
    endtask

    task automatic t_backup();
        pin_release = 8'h01;
        run_to(400, "R9 scan");
        backup = 1'b1;
        step();
        check_pins("R10 blanked in backup");
        write_digit(1, 4'b1100, "R10 write during backup");
        run(3, "R10 still blank");
        backup = 1'b0;
        step();
        check_pins("R10 restart at common 0 even frame");
        run(FR + 10, "R10 scan after backup");
        pin_release = 8'h00;
    endtask

    task automatic t_reset_mid();
        run_to(600, "R6 scan");
        rst = 1'b1;
        step();
        check_pins("R1 reset mid frame");
        rst = 1'b0;
        step();
        check_pins("R1 pattern cleared");
        run(FR + 5, "R1 blank pattern after reset");
    endtask

    initial begin
        for (int j = 0; j < NS; j++) begin shown[j] = '0; pend[j] = '0; end
        @(negedge clk);
        t_reset_state();
        t_scan();
        t_pattern();
        t_edge_write();
        t_range();
        t_release();
        t_backup();
        t_reset_mid();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, act=hung exp=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule